// File: doc/BRIEF.md
# Cache Injection Window Table

This block sits beside one processor's private cache and decides when that cache should take in a line that some other agent put on the shared bus. Software opens address windows in two steps. First it sets the low bound, then it sets the high bound, which makes the window live. Software can later close a window by naming its low bound. The table watches every data-carrying bus transfer. A transfer can be a read response sent to another processor, or an update or store-update pushed by a producer. When such a transfer's line address lies inside a live window and the local cache has no valid copy, the block tells the cache to install the line in the Shared state.

The table does not hold line data or coherence state of its own. The cache reports whether it holds a valid copy of the snooped line. The block passes the address and data of the line to install on its fill outputs one cycle after the snoop. A windowed consumer therefore picks up producer data without issuing a miss of its own.

Top module: `inj_window_table`

## Requirements
- R1: After reset no window is live, `fill_valid` is 0 and `overflow` is 0, so no snooped transfer is injected.
- R2: An open-low command (`cmd_op` = 2'b01) followed by an open-high command (`cmd_op` = 2'b10) makes a window live. An open-high command with no open-low pending is ignored.
- R3: Matching uses the line address (address bits above the 5 offset bits of a 32-byte line). It is inclusive at both the low and the high bound. A line just outside either bound is not injected.
- R4: A read-response transfer (`snp_cmd` = 2'b01) whose line lies in a live window is injected.
- R5: Update (`snp_cmd` = 2'b10) and store-update (`snp_cmd` = 2'b11) transfers in a live window are injected. A transfer of any other kind (`snp_cmd` = 2'b00) is never injected.
- R6: When `loc_line_valid` is 1 in the snoop cycle, no injection happens.
- R7: An injection shows on the fill outputs in the cycle after the snoop. `fill_addr` is the snooped address with the 5 offset bits cleared, `fill_data` is the snooped line, and `fill_state` is Shared (2'b01). When there is no injection, `fill_state` is 2'b00.
- R8: A close command (`cmd_op` = 2'b11) invalidates every live window whose low bound equals the command's line address. A close that matches no low bound has no effect.
- R9: An open-low command issued when all entries are live and none is pending is ignored and sets `overflow`. `overflow` stays set until reset.
- R10: A snoop is judged against the table as it stood before any command in the same cycle. A window being closed still injects that cycle, and a window being completed does not yet inject.
- R11: An open-low command issued while another open-low is pending replaces the pending low bound and uses no further entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Processor window command present |
| cmd_op | input | 2 | 01 open-low, 10 open-high, 11 close, 00 none |
| cmd_addr | input | ADDR_W | Bound address for the command |
| snp_valid | input | 1 | Bus transfer present |
| snp_cmd | input | 2 | 01 read response, 10 update, 11 store-update, 00 other |
| snp_addr | input | ADDR_W | Bus transfer address |
| snp_data | input | 8*LINE_BYTES | Bus transfer line data |
| loc_line_valid | input | 1 | Local cache holds a valid copy of the snooped line |
| fill_valid | output | 1 | Install the line on the fill outputs |
| fill_addr | output | ADDR_W | Line-aligned address to install |
| fill_data | output | 8*LINE_BYTES | Line data to install |
| fill_state | output | 2 | State for the installed line (01 Shared) |
| overflow | output | 1 | Sticky: an open-low was dropped for lack of an entry |

## Verification
A processor command and a bus snoop can arrive in the same cycle, so a close or a window completion can coincide with a transfer to that very window. The bench drives both in one cycle. It checks that a close still lets that transfer inject and that the next transfer is not injected. It then checks that a completing open-high does not inject the coincident transfer but does inject the following one.

// File: rtl/inj_win_pkg.sv
package inj_win_pkg;
   typedef enum logic [1:0] {
      OP_NONE    = 2'b00,
      OP_OPEN_LO = 2'b01,
      OP_OPEN_HI = 2'b10,
      OP_CLOSE   = 2'b11
   } win_op_e;

   typedef enum logic [1:0] {
      BUS_OTHER     = 2'b00,
      BUS_RD_RESP   = 2'b01,
      BUS_UPDATE    = 2'b10,
      BUS_ST_UPDATE = 2'b11
   } bus_cmd_e;

   typedef enum logic [1:0] {
      LS_INVALID = 2'b00,
      LS_SHARED  = 2'b01,
      LS_EXCL    = 2'b10,
      LS_MOD     = 2'b11
   } line_state_e;
endpackage

// File: rtl/inj_free_pick.sv
// Lowest-index free entry finder.
module inj_free_pick #(
   parameter int N     = 128,
   parameter int IDX_W = 7
) (
   input  logic [N-1:0]     busy_i,
   output logic             any_free_o,
   output logic [IDX_W-1:0] idx_o
);
   always_comb begin
      any_free_o = 1'b0;
      idx_o      = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!busy_i[i]) begin
            any_free_o = 1'b1;
            idx_o      = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/inj_range_match.sv
// Inclusive range compare of one probe line address against every entry.
module inj_range_match #(
   parameter int N    = 128,
   parameter int LA_W = 27
) (
   input  logic [LA_W-1:0] probe_i,
   input  logic [LA_W-1:0] lo_i [N],
   input  logic [LA_W-1:0] hi_i [N],
   input  logic [N-1:0]    vld_i,
   output logic            hit_o
);
   logic [N-1:0] hit_vec;

   for (genvar i = 0; i < N; i++) begin : g_ent
      assign hit_vec[i] = vld_i[i] && (probe_i >= lo_i[i]) && (probe_i <= hi_i[i]);
   end

   assign hit_o = |hit_vec;
endmodule

// File: rtl/inj_window_table.sv
module inj_window_table
   import inj_win_pkg::*;
#(
   parameter int ENTRIES    = 128,
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cmd_valid,
   input  logic [1:0]              cmd_op,
   input  logic [ADDR_W-1:0]       cmd_addr,
   input  logic                    snp_valid,
   input  logic [1:0]              snp_cmd,
   input  logic [ADDR_W-1:0]       snp_addr,
   input  logic [8*LINE_BYTES-1:0] snp_data,
   input  logic                    loc_line_valid,
   output logic                    fill_valid,
   output logic [ADDR_W-1:0]       fill_addr,
   output logic [8*LINE_BYTES-1:0] fill_data,
   output logic [1:0]              fill_state,
   output logic                    overflow
);
   localparam int OFS_W = $clog2(LINE_BYTES);
   localparam int LA_W  = ADDR_W - OFS_W;
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (LINE_BYTES < 2 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 2");
   end
   if (ENTRIES < 2) begin : g_bad_depth
      $error("ENTRIES must be at least 2");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr
      $error("ADDR_W must exceed the line offset width");
   end

   // Window storage
   logic [LA_W-1:0]  lo_q [ENTRIES];
   logic [LA_W-1:0]  hi_q [ENTRIES];
   logic [ENTRIES-1:0] vld_q;
   logic             pend_q;
   logic [IDX_W-1:0] pend_idx_q;
   logic             ovf_q;

   logic [LA_W-1:0]  cmd_la, snp_la;
   logic             any_free;
   logic [IDX_W-1:0] free_idx, wr_idx;
   logic             do_lo, do_hi, hit, inject;
   logic             unused_ofs;

   assign cmd_la     = cmd_addr[ADDR_W-1:OFS_W];
   assign snp_la     = snp_addr[ADDR_W-1:OFS_W];
   assign unused_ofs = ^{cmd_addr[OFS_W-1:0], snp_addr[OFS_W-1:0]};

   inj_free_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
      .busy_i     (vld_q),
      .any_free_o (any_free),
      .idx_o      (free_idx)
   );

   assign wr_idx = pend_q ? pend_idx_q : free_idx;
   assign do_lo  = cmd_valid && (cmd_op == OP_OPEN_LO) && (pend_q || any_free);
   assign do_hi  = cmd_valid && (cmd_op == OP_OPEN_HI) && pend_q;

   // Entry control: valid bits, pending slot, overflow
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q      <= '0;
         pend_q     <= 1'b0;
         pend_idx_q <= '0;
         ovf_q      <= 1'b0;
      end else if (cmd_valid) begin
         case (cmd_op)
            OP_OPEN_LO: begin
               if (do_lo) begin
                  pend_q     <= 1'b1;
                  pend_idx_q <= wr_idx;
               end else begin
                  ovf_q <= 1'b1;
               end
            end
            OP_OPEN_HI: begin
               if (pend_q) begin
                  vld_q[pend_idx_q] <= 1'b1;
                  pend_q            <= 1'b0;
               end
            end
            OP_CLOSE: begin
               for (int i = 0; i < ENTRIES; i++) begin
                  if (vld_q[i] && lo_q[i] == cmd_la) vld_q[i] <= 1'b0;
               end
            end
            default: ;
         endcase
      end
   end

   // Bound storage, no reset needed behind the valid bits
   always_ff @(posedge clk) begin
      if (do_lo) lo_q[wr_idx]     <= cmd_la;
      if (do_hi) hi_q[pend_idx_q] <= cmd_la;
   end

   inj_range_match #(.N(ENTRIES), .LA_W(LA_W)) u_match (
      .probe_i (snp_la),
      .lo_i    (lo_q),
      .hi_i    (hi_q),
      .vld_i   (vld_q),
      .hit_o   (hit)
   );

   assign inject = snp_valid && (snp_cmd != BUS_OTHER) && !loc_line_valid && hit;

   logic                    fill_v_q;
   logic [LA_W-1:0]         fill_la_q;
   logic [8*LINE_BYTES-1:0] fill_d_q;

   always_ff @(posedge clk) begin
      if (!rst_n) fill_v_q <= 1'b0;
      else        fill_v_q <= inject;
   end

   always_ff @(posedge clk) begin
      if (inject) begin
         fill_la_q <= snp_la;
         fill_d_q  <= snp_data;
      end
   end

   assign fill_valid = fill_v_q;
   assign fill_addr  = {fill_la_q, {OFS_W{1'b0}}};
   assign fill_data  = fill_d_q;
   assign fill_state = fill_v_q ? LS_SHARED : LS_INVALID;
   assign overflow   = ovf_q;
endmodule

// File: rtl/inj_window_table_chk.sv
module inj_window_table_chk #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    snp_valid,
   input logic [1:0]              snp_cmd,
   input logic [ADDR_W-1:0]       snp_addr,
   input logic [8*LINE_BYTES-1:0] snp_data,
   input logic                    loc_line_valid,
   input logic                    fill_valid,
   input logic [ADDR_W-1:0]       fill_addr,
   input logic [8*LINE_BYTES-1:0] fill_data,
   input logic [1:0]              fill_state,
   input logic                    overflow
);
   localparam int OFS_W = $clog2(LINE_BYTES);

   assert_fill_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> $past(snp_valid && !loc_line_valid && snp_cmd != 2'b00));

   assert_no_fill_other_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_cmd == 2'b00) |=> !fill_valid);

   assert_fill_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> (fill_addr[ADDR_W-1:OFS_W] == $past(snp_addr[ADDR_W-1:OFS_W])
                      && fill_addr[OFS_W-1:0] == '0 && fill_state == 2'b01));

   assert_fill_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> fill_data == $past(snp_data));

   assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);
endmodule

bind inj_window_table inj_window_table_chk #(
   .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
   .snp_addr(snp_addr), .snp_data(snp_data), .loc_line_valid(loc_line_valid),
   .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
   .fill_state(fill_state), .overflow(overflow)
);

// File: tb/inj_window_table_tb.sv
module inj_window_table_tb;
   localparam int CLK_PERIOD = 10;
   localparam int ENT = 4;
   localparam int AW  = 32;
   localparam int LB  = 32;
   localparam int DW  = 8 * LB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = 2'b00;
   logic [AW-1:0] cmd_addr = '0;
   logic          snp_valid = 1'b0;
   logic [1:0]    snp_cmd = 2'b00;
   logic [AW-1:0] snp_addr = '0;
   logic [DW-1:0] snp_data = '0;
   logic          loc_line_valid = 1'b0;
   logic          fill_valid;
   logic [AW-1:0] fill_addr;
   logic [DW-1:0] fill_data;
   logic [1:0]    fill_state;
   logic          overflow;

   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   inj_window_table #(.ENTRIES(ENT), .ADDR_W(AW), .LINE_BYTES(LB)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
      .snp_addr(snp_addr), .snp_data(snp_data), .loc_line_valid(loc_line_valid),
      .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
      .fill_state(fill_state), .overflow(overflow)
   );

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   // One cycle: optional command and optional snoop driven together, outputs sampled after the edge
   task automatic step(input logic cv, input logic [1:0] op, input logic [AW-1:0] ca,
                       input logic sv, input logic [1:0] sc, input logic [AW-1:0] sa,
                       input logic [DW-1:0] sd, input logic lv);
      cmd_valid = cv; cmd_op = op; cmd_addr = ca;
      snp_valid = sv; snp_cmd = sc; snp_addr = sa; snp_data = sd; loc_line_valid = lv;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'b00; snp_valid = 1'b0; loc_line_valid = 1'b0;
   endtask

   task automatic cmd(input logic [1:0] op, input logic [AW-1:0] a);
      step(1'b1, op, a, 1'b0, 2'b00, '0, '0, 1'b0);
   endtask

   task automatic open_win(input logic [AW-1:0] lo, input logic [AW-1:0] hi);
      cmd(2'b01, lo);
      cmd(2'b10, hi);
   endtask

   // Snoop and judge the fill in the next cycle
   task automatic snoop_exp(input string tag, input logic [1:0] sc, input logic [AW-1:0] sa,
                            input logic lv, input logic exp_fill);
      logic [DW-1:0] d;
      d = {8{sa ^ 32'h5A5A_0000}};
      step(1'b0, 2'b00, '0, 1'b1, sc, sa, d, lv);
      chk(tag, DW'(fill_valid), DW'(exp_fill));
      if (exp_fill) begin
         chk({tag, " addr"}, DW'(fill_addr), DW'({sa[AW-1:5], 5'b0}));
         chk({tag, " data"}, fill_data, d);
         chk({tag, " state"}, DW'(fill_state), DW'(2'b01));
      end else begin
         chk({tag, " state"}, DW'(fill_state), DW'(2'b00));
      end
   endtask

   task automatic t_reset;
      chk("R1 fill_valid", DW'(fill_valid), '0);
      chk("R1 overflow", DW'(overflow), '0);
      snoop_exp("R1 empty table", 2'b01, 32'h1000, 1'b0, 1'b0);
   endtask

   task automatic t_bounds;
      open_win(32'h1000, 32'h10E0);
      snoop_exp("R4 low bound", 2'b01, 32'h1000, 1'b0, 1'b1);
      snoop_exp("R3 high bound offset ignored", 2'b01, 32'h10FF, 1'b0, 1'b1);
      snoop_exp("R3 below low", 2'b01, 32'h0FFF, 1'b0, 1'b0);
      snoop_exp("R3 above high", 2'b01, 32'h1100, 1'b0, 1'b0);
   endtask

   task automatic t_orphan_high;
      cmd(2'b10, 32'h3000);
      snoop_exp("R2 orphan high ignored", 2'b01, 32'h3000, 1'b0, 1'b0);
   endtask

   task automatic t_update;
      snoop_exp("R5 update", 2'b10, 32'h1040, 1'b0, 1'b1);
      snoop_exp("R5 store-update", 2'b11, 32'h1060, 1'b0, 1'b1);
      snoop_exp("R5 other kind", 2'b00, 32'h1060, 1'b0, 1'b0);
   endtask

   task automatic t_local_valid;
      snoop_exp("R6 local copy valid", 2'b01, 32'h1020, 1'b1, 1'b0);
   endtask

   task automatic t_close;
      cmd(2'b11, 32'h1020);
      snoop_exp("R8 non-matching close", 2'b01, 32'h1020, 1'b0, 1'b1);
      cmd(2'b11, 32'h1000);
      snoop_exp("R8 closed window", 2'b01, 32'h1020, 1'b0, 1'b0);
   endtask

   task automatic t_relow;
      cmd(2'b01, 32'h5000);
      cmd(2'b01, 32'h6000);
      cmd(2'b10, 32'h6100);
      snoop_exp("R11 replaced low", 2'b01, 32'h5000, 1'b0, 1'b0);
      snoop_exp("R11 new window", 2'b01, 32'h6080, 1'b0, 1'b1);
   endtask

   task automatic t_same_cycle;
      open_win(32'h2000, 32'h2000);
      step(1'b1, 2'b11, 32'h2000, 1'b1, 2'b01, 32'h2000, {8{32'hC0DE_0001}}, 1'b0);
      chk("R10 close same cycle injects", DW'(fill_valid), DW'(1'b1));
      snoop_exp("R10 after close", 2'b01, 32'h2000, 1'b0, 1'b0);
      cmd(2'b01, 32'h2400);
      step(1'b1, 2'b10, 32'h2400, 1'b1, 2'b10, 32'h2400, {8{32'hC0DE_0002}}, 1'b0);
      chk("R10 completing window no inject", DW'(fill_valid), DW'(1'b0));
      snoop_exp("R10 after completion", 2'b10, 32'h2400, 1'b0, 1'b1);
   endtask

   task automatic t_overflow;
      open_win(32'h7000, 32'h7000);
      open_win(32'h8000, 32'h8000);
      chk("R9 not yet full", DW'(overflow), '0);
      open_win(32'h9000, 32'h9000);
      chk("R9 overflow set", DW'(overflow), DW'(1'b1));
      snoop_exp("R9 dropped window", 2'b01, 32'h9000, 1'b0, 1'b0);
      cmd(2'b11, 32'h7000);
      chk("R9 overflow sticky", DW'(overflow), DW'(1'b1));
      open_win(32'h9000, 32'h9000);
      snoop_exp("R9 freed entry reused", 2'b01, 32'h9000, 1'b0, 1'b1);
      chk("R9 still sticky", DW'(overflow), DW'(1'b1));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_bounds();
      t_orphan_high();
      t_update();
      t_local_valid();
      t_close();
      t_relow();
      t_same_cycle();
      t_overflow();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end
endmodule